// File: doc/BRIEF.md
# Write-Back Write-Allocate Byte Cache Controller

This block sits between a processor's byte load/store port and a slow block memory. It holds two fully associative lines, each caching one two-byte block of a 4-bit byte address space (3-bit block tag, 1-bit byte offset). Loads and stores that hit are served from the line without touching memory. A store hit updates only the addressed byte and marks the line modified.

On a miss the controller picks a victim line. An empty line is taken first. When both lines are occupied, the choice alternates between them. A modified victim is copied back to memory as a whole block before the requested block is read in. A clean victim is dropped without any memory traffic. A store miss fetches the block first and then merges the stored byte into it, so the new line starts out modified. Memory sees one block-wide request at a time, held until acknowledged. A counter of completed block writes lets the environment measure how much write traffic the cache generated.

Top module: `wb_cache_ctrl`

## Requirements
- R1: After reset both lines are empty, `cpu_ready` is 1, `mem_req` is 0 and `mem_wr_count` is 0; the first access after reset is a miss.
- R2: A load to a resident block returns the addressed byte with `cpu_hit`=1 and issues no memory request.
- R3: A store to a resident block replaces only the addressed byte (offset 0 is the low byte of the block, offset 1 the high byte), returns the stored byte on `cpu_rdata`, and causes no memory request and no change of `mem_wr_count`.
- R4: On a miss while a line is empty, the lowest-numbered empty line is filled and no memory write occurs.
- R5: On a miss with both lines occupied, the victim is the line after the one most recently filled (line 0 after line 1 and line 1 after line 0).
- R6: A clean victim is discarded without a memory write: the miss costs exactly one memory read.
- R7: A modified victim is written as its full block to its own block address (`mem_we`=1) before the fill read, and `mem_wr_count` rises by exactly one.
- R8: A store miss reads the block from memory, merges the stored byte and leaves the line modified, so its later eviction writes the merged block.
- R9: A load miss returns the requested byte of the fetched block with `cpu_hit`=0 and leaves the line clean.
- R10: `mem_req`, `mem_we` and `mem_addr` stay stable from the rise of `mem_req` until the cycle `mem_ack` is seen; `mem_addr` is the block number (byte address divided by two).
- R11: Each accepted request produces exactly one single-cycle `cpu_done` pulse, and `cpu_ready` stays 0 between acceptance and that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, taken when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 4 | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_ready | output | 1 | Controller idle and able to take a request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Completed access hit a resident line |
| cpu_rdata | output | 8 | Loaded byte, or the stored byte for a store |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block fill read |
| mem_addr | output | 3 | Block number |
| mem_wdata | output | 16 | Block being written back |
| mem_ack | input | 1 | Memory has completed the transfer |
| mem_rdata | input | 16 | Fill block, valid with `mem_ack` |
| mem_wr_count | output | 16 | Number of completed block write-backs |

## Verification
A lost or spurious dirty bit shows up at the memory port: either a write-back is missing when a modified line leaves, so a later load of that block returns the stale memory byte, or an extra write appears and `mem_wr_count` moves at a clean eviction. A wrong victim or a stale valid bit shows up as an unexpected hit flag or transaction count on the very next access to the affected block. Because lines are tiny and only two exist, every such fault reaches the ports within two or three accesses of the sequence that creates it. The bench also records each memory transaction's direction and block number, so write-before-read ordering and the merged block contents are compared directly.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WBACK  = 2'd2,
        ST_FILL   = 2'd3
    } wbc_state_e;

endpackage

// File: rtl/wbc_tag_match.sv
module wbc_tag_match #(
    parameter int NLINES = 2,
    parameter int TAG_W  = 3,
    localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NLINES-1:0]             vld,
    input  logic [NLINES-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]              req_tag,
    output logic                          hit_any,
    output logic [IDX_W-1:0]              hit_idx
);

    logic [NLINES-1:0] hit_vec;

    for (genvar g = 0; g < NLINES; g++) begin : g_cmp
        assign hit_vec[g] = vld[g] && (tags[g] == req_tag);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit_any = |hit_vec;

    // A block may be resident in at most one line
    assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/wbc_victim_sel.sv
module wbc_victim_sel #(
    parameter int NLINES = 2,
    localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] vld,
    input  logic [IDX_W-1:0]  rr_ptr,
    output logic [IDX_W-1:0]  vic_idx
);

    logic             any_free;
    logic [IDX_W-1:0] free_idx;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
        vic_idx = any_free ? free_idx : rr_ptr;
    end

    assert_empty_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld != {NLINES{1'b1}}) |-> !vld[vic_idx]);

    assert_rr_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (vld == {NLINES{1'b1}}) |-> (vic_idx == rr_ptr));

endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int OFF_W  = 1,
    parameter int NLINES = 2,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 16,
    localparam int TAG_W = ADDR_W - OFF_W,
    localparam int BPB   = 1 << OFF_W,
    localparam int BLK_W = BPB * BYTE_W,
    localparam int IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [TAG_W-1:0]  mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [BLK_W-1:0]  mem_rdata,
    output logic [CNT_W-1:0]  mem_wr_count
);

    typedef struct packed {
        wbc_state_e                        st;
        logic [NLINES-1:0]                 vld;
        logic [NLINES-1:0]                 dty;
        logic [NLINES-1:0][TAG_W-1:0]      tag;
        logic [NLINES-1:0][BLK_W-1:0]      blk;
        logic [IDX_W-1:0]                  rr;
        logic [IDX_W-1:0]                  vic;
        logic [ADDR_W-1:0]                 addr;
        logic                              we;
        logic [BYTE_W-1:0]                 wd;
        logic                              done;
        logic                              hit;
        logic [BYTE_W-1:0]                 rd;
        logic [CNT_W-1:0]                  wcnt;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [TAG_W-1:0] req_tag;
    logic [OFF_W-1:0] req_off;
    logic             hit_any;
    logic [IDX_W-1:0] hit_idx;
    logic [IDX_W-1:0] vic_idx;
    logic [IDX_W-1:0] rr_next;

    assign req_tag = c_q.addr[ADDR_W-1:OFF_W];
    assign req_off = c_q.addr[OFF_W-1:0];

    wbc_tag_match #(.NLINES(NLINES), .TAG_W(TAG_W)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (c_q.vld),
        .tags    (c_q.tag),
        .req_tag (req_tag),
        .hit_any (hit_any),
        .hit_idx (hit_idx)
    );

    wbc_victim_sel #(.NLINES(NLINES)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld     (c_q.vld),
        .rr_ptr  (c_q.rr),
        .vic_idx (vic_idx)
    );

    // Pointer advances to the line after the one just filled
    assign rr_next = (int'(c_q.vic) == NLINES - 1) ? '0 : c_q.vic + 1'b1;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (cpu_req) begin
                    c_d.addr = cpu_addr;
                    c_d.we   = cpu_we;
                    c_d.wd   = cpu_wdata;
                    c_d.st   = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (hit_any) begin
                    if (c_q.we) begin
                        c_d.blk[hit_idx][int'(req_off)*BYTE_W +: BYTE_W] = c_q.wd;
                        c_d.dty[hit_idx] = 1'b1;
                        c_d.rd           = c_q.wd;
                    end else begin
                        c_d.rd = c_q.blk[hit_idx][int'(req_off)*BYTE_W +: BYTE_W];
                    end
                    c_d.hit  = 1'b1;
                    c_d.done = 1'b1;
                    c_d.st   = ST_IDLE;
                end else begin
                    c_d.vic = vic_idx;
                    c_d.hit = 1'b0;
                    if (c_q.vld[vic_idx] && c_q.dty[vic_idx]) begin
                        c_d.st = ST_WBACK;
                    end else begin
                        c_d.vld[vic_idx] = 1'b0;
                        c_d.st           = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    c_d.vld[c_q.vic] = 1'b0;
                    c_d.dty[c_q.vic] = 1'b0;
                    c_d.wcnt         = c_q.wcnt + 1'b1;
                    c_d.st           = ST_FILL;
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    c_d.blk[c_q.vic] = mem_rdata;
                    c_d.tag[c_q.vic] = req_tag;
                    c_d.vld[c_q.vic] = 1'b1;
                    c_d.dty[c_q.vic] = 1'b0;
                    if (c_q.we) begin
                        c_d.blk[c_q.vic][int'(req_off)*BYTE_W +: BYTE_W] = c_q.wd;
                        c_d.dty[c_q.vic] = 1'b1;
                        c_d.rd           = c_q.wd;
                    end else begin
                        c_d.rd = mem_rdata[int'(req_off)*BYTE_W +: BYTE_W];
                    end
                    c_d.rr   = rr_next;
                    c_d.done = 1'b1;
                    c_d.st   = ST_IDLE;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cpu_ready    = (c_q.st == ST_IDLE);
    assign cpu_done     = c_q.done;
    assign cpu_hit      = c_q.hit;
    assign cpu_rdata    = c_q.rd;
    assign mem_req      = (c_q.st == ST_WBACK) || (c_q.st == ST_FILL);
    assign mem_we       = (c_q.st == ST_WBACK);
    assign mem_addr     = (c_q.st == ST_WBACK) ? c_q.tag[c_q.vic] : req_tag;
    assign mem_wdata    = c_q.blk[c_q.vic];
    assign mem_wr_count = c_q.wcnt;

    assert_wback_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_WBACK) |-> (c_q.vld[c_q.vic] && c_q.dty[c_q.vic]));

    assert_wcnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> (mem_wr_count == CNT_W'($past(mem_wr_count) + 1'b1)));

    assert_hit_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_q.st == ST_LOOKUP) && hit_any) |=> (!mem_req && $stable(mem_wr_count)));

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> !mem_req);

endmodule

// File: tb/wb_cache_ctrl_tb.sv
module wb_cache_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req, cpu_we;
    logic [3:0]  cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_ready, cpu_done, cpu_hit;
    logic [7:0]  cpu_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [2:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [15:0] mem_wr_count;

    always #4 clk = ~clk;   // 125 MHz

    wb_cache_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_wr_count(mem_wr_count)
    );

    int checks = 0;
    int errors = 0;
    bit timeout = 0;

    logic [7:0] mem [16];
    logic       tr_we   [64];
    logic [2:0] tr_addr [64];
    int         tr_n = 0;

    // Vector: {we, addr, wdata, exp_rdata, exp_hit, exp_wcnt, exp_txn}
    localparam int NV = 15;
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 4'd1,  8'h00, 8'hA1, 1'b0, 4'd0, 2'd1},  // R4 miss into empty line 0
        {1'b0, 4'd7,  8'h00, 8'hA7, 1'b0, 4'd0, 2'd1},  // R4 miss into empty line 1
        {1'b1, 4'd0,  8'h55, 8'h55, 1'b1, 4'd0, 2'd0},  // R3 store hit
        {1'b1, 4'd0,  8'h66, 8'h66, 1'b1, 4'd0, 2'd0},  // R3 repeated store hit
        {1'b1, 4'd1,  8'h77, 8'h77, 1'b1, 4'd0, 2'd0},  // R3 store other byte
        {1'b0, 4'd0,  8'h00, 8'h66, 1'b1, 4'd0, 2'd0},  // R2 load hit
        {1'b0, 4'd5,  8'h00, 8'hA5, 1'b0, 4'd1, 2'd2},  // R5 R7 dirty line 0 evicted
        {1'b0, 4'd10, 8'h00, 8'hAA, 1'b0, 4'd1, 2'd1},  // R5 R6 clean line 1 evicted
        {1'b1, 4'd11, 8'h99, 8'h99, 1'b1, 4'd1, 2'd0},  // R3 store hit high byte
        {1'b1, 4'd3,  8'h12, 8'h12, 1'b0, 4'd1, 2'd1},  // R8 store miss, clean victim
        {1'b0, 4'd1,  8'h00, 8'h77, 1'b0, 4'd2, 2'd2},  // R7 write-back then refetch
        {1'b0, 4'd0,  8'h00, 8'h66, 1'b1, 4'd2, 2'd0},  // R2 R9
        {1'b0, 4'd11, 8'h00, 8'h99, 1'b0, 4'd3, 2'd2},  // R8 merged block written back
        {1'b0, 4'd3,  8'h00, 8'h12, 1'b0, 4'd3, 2'd1},  // R9 refetched line was clean
        {1'b0, 4'd10, 8'h00, 8'hAA, 1'b1, 4'd3, 2'd0}   // R2
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Memory model: acknowledges two cycles after a request is seen
    initial begin
        int lat;
        mem_ack = 1'b0;
        mem_rdata = '0;
        lat = 0;
        for (int i = 0; i < 16; i++) mem[i] = 8'hA0 + 8'(i);
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                lat++;
                if (lat == 2) begin
                    lat = 0;
                    mem_ack = 1'b1;
                    if (tr_n < 64) begin
                        tr_we[tr_n]   = mem_we;
                        tr_addr[tr_n] = mem_addr;
                        tr_n++;
                    end
                    if (mem_we) begin
                        mem[{mem_addr, 1'b0}] = mem_wdata[7:0];
                        mem[{mem_addr, 1'b1}] = mem_wdata[15:8];
                    end else begin
                        mem_rdata = {mem[{mem_addr, 1'b1}], mem[{mem_addr, 1'b0}]};
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        timeout = 1'b1;
    end

    task automatic do_op(input logic we, input logic [3:0] addr, input logic [7:0] wd,
                         output logic [7:0] rd, output logic hit, output bit busy_ok);
        while (!cpu_ready && !timeout) @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        busy_ok = 1'b1;
        while (!cpu_done && !timeout) begin
            if (cpu_ready) busy_ok = 1'b0;
            @(negedge clk);
        end
        rd = cpu_rdata;
        hit = cpu_hit;
        @(negedge clk);
        if (cpu_done) busy_ok = 1'b0;
    endtask

    initial begin
        logic [7:0] rd;
        logic hit;
        bit busy_ok;
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cpu_ready == 1'b1, "R1 ready", 32'(cpu_ready), 1);
        check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 0);
        check(mem_wr_count == 16'd0, "R1 wr_count", 32'(mem_wr_count), 0);

        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            int base;
            v = VEC[i];
            base = tr_n;
            do_op(v[27], v[26:23], v[22:15], rd, hit, busy_ok);
            check(rd == v[14:7], $sformatf("R2/R3/R8/R9 rdata step %0d", i), 32'(rd), 32'(v[14:7]));
            check(hit == v[6], $sformatf("R2/R4/R6 hit step %0d", i), 32'(hit), 32'(v[6]));
            check(mem_wr_count == 16'(v[5:2]), $sformatf("R3/R6/R7 wr_count step %0d", i),
                  32'(mem_wr_count), 32'(v[5:2]));
            check((tr_n - base) == int'(v[1:0]), $sformatf("R2/R6/R7 txn count step %0d", i),
                  32'(tr_n - base), 32'(v[1:0]));
            check(busy_ok, $sformatf("R11 ready/done step %0d", i), 32'(busy_ok), 1);
            if (i == 6) begin
                // R7 write of block 0 precedes fill of block 2; merged bytes reach memory
                check(tr_we[base] == 1'b1 && tr_addr[base] == 3'd0, "R7 first txn write blk0",
                      {28'd0, tr_we[base], tr_addr[base]}, 32'h8);
                check(tr_we[base+1] == 1'b0 && tr_addr[base+1] == 3'd2, "R10 second txn read blk2",
                      {28'd0, tr_we[base+1], tr_addr[base+1]}, 32'h2);
                check(mem[0] == 8'h66 && mem[1] == 8'h77, "R7 written block",
                      {16'd0, mem[1], mem[0]}, 32'h7766);
            end
            if (i == 12) begin
                check(mem[2] == 8'hA2 && mem[3] == 8'h12, "R8 merged block in memory",
                      {16'd0, mem[3], mem[2]}, 32'h12A2);
            end
        end
        check(mem[10] == 8'hAA && mem[11] == 8'h99, "R7 block 5 written",
              {16'd0, mem[11], mem[10]}, 32'h99AA);

        // R1 reset mid-run empties the lines and clears the counter
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(mem_wr_count == 16'd0, "R1 wr_count after reset", 32'(mem_wr_count), 0);
        check(cpu_ready == 1'b1 && mem_req == 1'b0, "R1 idle after reset",
              {30'd0, cpu_ready, mem_req}, 32'h2);
        begin
            int base;
            base = tr_n;
            do_op(1'b0, 4'd10, 8'h00, rd, hit, busy_ok);
            check(hit == 1'b0, "R1 first access misses", 32'(hit), 0);
            check(rd == 8'hAA, "R9 refetched byte", 32'(rd), 32'hAA);
            check((tr_n - base) == 1, "R4 empty line no write-back", 32'(tr_n - base), 1);
        end

        if (timeout) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule